// File: doc/BRIEF.md
# Busy-Gated Clock-Crossing Register Write

This block moves writes for two control registers from the CPU bus clock into the audio converter clock. One register holds the oversampling and clock selection settings. The other holds the converter control settings. A write that the bus side accepts is latched into a holding register. The block then flips a request toggle. That toggle passes through two flops into the converter domain, where the target register loads the held value. An acknowledge toggle returns through two flops into the bus domain.

Both registers share a single busy flag. It rises on the bus edge that accepts a write. It falls only after the acknowledge has come back. A write to either register that arrives while busy is high is dropped. It is neither queued nor stalled, and it does not change the timing of the transfer already in flight. Software must poll the busy bit before each write.

Top module: `busy_gated_reg_xfer`

## Requirements
- R1: While the resets are asserted, `busy` is 0, `osr_val` equals `OSR_RST` and `ctl_val` equals `CTL_RST`.
- R2: A bus-clock edge with `wr_en`=1 and `busy`=0 accepts the write, and `busy` reads 1 after that edge.
- R3: The register named by an accepted write takes the written data on the third converter-clock edge after the accepting bus edge. No other register value changes at any time.
- R4: `busy` returns to 0 on the third bus-clock edge after the converter edge that loaded the register.
- R5: A write seen on a bus edge while `busy`=1 is discarded. It changes no register and moves neither the loaded value nor the edge on which `busy` clears.
- R6: The discard in R5 applies whether the second write targets the same register as the one in flight or the other register.
- R7: Address encoding: `wr_addr`=0 selects the oversampling register (`osr_val`), and `wr_addr`=1 selects the control register (`ctl_val`).
- R8: After a write is accepted, changes on `wr_addr` and `wr_data` have no effect on the value delivered to the converter domain.
- R9: When `wr_en` is held high across a transfer, a new write is accepted on the first bus edge at which `busy` is 0. The last accepted value is the one that remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | CPU bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe, bus domain |
| wr_addr | input | 1 | Register select: 0 oversampling, 1 control |
| wr_data | input | DATA_W | Write data |
| busy | output | 1 | High while a write crossing is in flight |
| clk_cnv | input | 1 | Audio converter clock |
| rst_cnv_n | input | 1 | Asynchronous active-low reset, converter domain |
| osr_val | output | DATA_W | Oversampling register, converter domain |
| ctl_val | output | DATA_W | Control register, converter domain |

## Verification
Each result has a fixed due time. `busy` is due one bus edge after acceptance. The register load is due on the third converter edge after acceptance. The clear of `busy` is due on the third bus edge after that load. The bench picks clock phases so that bus and converter edges never coincide, which keeps "the n-th edge after" unambiguous. A behavioural model counts edges in each domain. `busy` is compared on every bus falling edge and both registers on every converter falling edge, so every check lands after the edge that was due to change the value. Directed sequences then add named checks on dropped writes, held inputs and back-to-back acceptance.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
    localparam int CWR_NREG = 2;

    typedef enum logic [0:0] {
        SEL_OSR = 1'b0,
        SEL_CTL = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/cwr_sync2.sv
module cwr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/cwr_bus_side.sv
module cwr_bus_side
    import cwr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_sync,
    output logic              req_tgl,
    output reg_sel_e          hold_sel,
    output logic [DATA_W-1:0] hold_data,
    output logic              busy
);
    typedef struct packed {
        logic              req;
        logic              busy;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_en && !st_q.busy;
        if (st_q.busy && (ack_sync == st_q.req)) begin
            st_d.busy = 1'b0;
        end
        if (accept) begin
            st_d.req  = ~st_q.req;
            st_d.busy = 1'b1;
            st_d.sel  = wr_sel;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{req: 1'b0, busy: 1'b0, sel: SEL_OSR, data: '0};
        else        st_q <= st_d;
    end

    assign req_tgl   = st_q.req;
    assign hold_sel  = st_q.sel;
    assign hold_data = st_q.data;
    assign busy      = st_q.busy;

    assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> busy);

    assert_drop_keeps_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(hold_data) && $stable(hold_sel) && $stable(req_tgl)));

    assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ack_sync == req_tgl)) |=> !busy);

    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ack_sync != req_tgl)) |=> busy);
endmodule

// File: rtl/cwr_cnv_side.sv
module cwr_cnv_side
    import cwr_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] OSR_RST = '0,
    parameter logic [DATA_W-1:0] CTL_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  reg_sel_e          hold_sel,
    input  logic [DATA_W-1:0] hold_data,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] osr_val,
    output logic [DATA_W-1:0] ctl_val
);
    localparam int NREG = CWR_NREG;

    typedef struct packed {
        logic                        ack;
        logic [NREG-1:0][DATA_W-1:0] regs;
    } cnv_st_t;

    cnv_st_t                     st_d, st_q;
    logic                        load;
    logic [NREG-1:0]             hit;
    logic [NREG-1:0][DATA_W-1:0] reg_nxt;

    assign load = (req_sync != st_q.ack);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign hit[g]     = load && (int'(hold_sel) == g);
        assign reg_nxt[g] = hit[g] ? hold_data : st_q.regs[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.regs = reg_nxt;
        if (load) st_d.ack = req_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {1'b0, CTL_RST, OSR_RST};
        else        st_q <= st_d;
    end

    assign ack_tgl = st_q.ack;
    assign osr_val = st_q.regs[int'(SEL_OSR)];
    assign ctl_val = st_q.regs[int'(SEL_CTL)];

    assert_quiet_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync == ack_tgl) |=> ($stable(osr_val) && $stable(ctl_val)));

    assert_ack_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync != ack_tgl) |=> (ack_tgl == $past(req_sync)));

    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(osr_val) || $stable(ctl_val)));
endmodule

// File: rtl/busy_gated_reg_xfer.sv
module busy_gated_reg_xfer
    import cwr_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] OSR_RST = '0,
    parameter logic [DATA_W-1:0] CTL_RST = '0
) (
    input  logic              clk_bus,
    input  logic              rst_bus_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    input  logic              clk_cnv,
    input  logic              rst_cnv_n,
    output logic [DATA_W-1:0] osr_val,
    output logic [DATA_W-1:0] ctl_val
);
    logic              req_tgl, req_sync;
    logic              ack_tgl, ack_sync;
    reg_sel_e          hold_sel;
    logic [DATA_W-1:0] hold_data;

    cwr_bus_side #(.DATA_W(DATA_W)) u_bus (
        .clk       (clk_bus),
        .rst_n     (rst_bus_n),
        .wr_en     (wr_en),
        .wr_sel    (reg_sel_e'(wr_addr)),
        .wr_data   (wr_data),
        .ack_sync  (ack_sync),
        .req_tgl   (req_tgl),
        .hold_sel  (hold_sel),
        .hold_data (hold_data),
        .busy      (busy)
    );

    cwr_sync2 #(.W(1)) u_req_sync (
        .clk   (clk_cnv),
        .rst_n (rst_cnv_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    cwr_sync2 #(.W(1)) u_ack_sync (
        .clk   (clk_bus),
        .rst_n (rst_bus_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );

    cwr_cnv_side #(
        .DATA_W  (DATA_W),
        .OSR_RST (OSR_RST),
        .CTL_RST (CTL_RST)
    ) u_cnv (
        .clk       (clk_cnv),
        .rst_n     (rst_cnv_n),
        .req_sync  (req_sync),
        .hold_sel  (hold_sel),
        .hold_data (hold_data),
        .ack_tgl   (ack_tgl),
        .osr_val   (osr_val),
        .ctl_val   (ctl_val)
    );
endmodule

// File: tb/busy_gated_reg_xfer_tb_top.sv
module busy_gated_reg_xfer_tb_top;
    localparam int DW = 8;

    logic          clk_bus = 1'b0;
    logic          clk_cnv = 1'b0;
    logic          rst_n   = 1'b0;
    logic          wr_en   = 1'b0;
    logic          wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          busy;
    logic [DW-1:0] osr_val, ctl_val;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // model state: bus process owns m_busy, m_acc, pend_*; converter process owns m_done, m_osr, m_ctl
    bit            m_busy   = 0;
    int            m_acc    = 0;
    int            m_done   = 0;
    int            bus_cnt  = 0;
    int            cnv_cnt  = 0;
    bit            pend_sel = 0;
    logic [DW-1:0] pend_dat = '0;
    logic [DW-1:0] m_osr    = '0;
    logic [DW-1:0] m_ctl    = '0;

    busy_gated_reg_xfer #(.DATA_W(DW)) dut_i (
        .clk_bus   (clk_bus),
        .rst_bus_n (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .clk_cnv   (clk_cnv),
        .rst_cnv_n (rst_n),
        .osr_val   (osr_val),
        .ctl_val   (ctl_val)
    );

    // bus: posedges at 5+10k (odd), converter: posedges at 2+16k (even) - never coincident
    always #5 clk_bus = ~clk_bus;
    initial begin
        #2;
        forever begin
            clk_cnv = 1'b1; #8;
            clk_cnv = 1'b0; #8;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // bus-domain reference model
    always @(posedge clk_bus) begin
        if (!rst_n) begin
            m_busy = 0; m_acc = 0; bus_cnt = 0;
        end else begin
            bit acc;
            acc = wr_en && !m_busy;
            if (m_busy && (m_done == m_acc)) begin
                bus_cnt++;
                if (bus_cnt == 3) begin
                    m_busy  = 0;
                    bus_cnt = 0;
                end
            end
            if (acc) begin
                m_busy   = 1;
                pend_sel = wr_addr;
                pend_dat = wr_data;
                bus_cnt  = 0;
                m_acc++;
            end
        end
    end

    // converter-domain reference model
    always @(posedge clk_cnv) begin
        if (!rst_n) begin
            m_done = 0; cnv_cnt = 0; m_osr = '0; m_ctl = '0;
        end else if (m_acc > m_done) begin
            cnv_cnt++;
            if (cnv_cnt == 3) begin
                if (pend_sel) m_ctl = pend_dat;
                else          m_osr = pend_dat;
                cnv_cnt = 0;
                m_done++;
            end
        end
    end

    // per-clock comparisons on falling edges
    always @(negedge clk_bus) begin
        if (rst_n && !finished) check(m_busy ? "R2 busy" : "R4 busy", DW'(busy), DW'(m_busy));
    end
    always @(negedge clk_cnv) begin
        if (rst_n && !finished) begin
            check("R3 osr", osr_val, m_osr);
            check("R3 ctl", ctl_val, m_ctl);
        end
    end

    task automatic write1(input bit a, input logic [DW-1:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk_bus);
        while (m_busy || (m_acc != m_done)) @(negedge clk_bus);
        repeat (2) @(negedge clk_bus);
    endtask

    initial begin
        repeat (3) @(negedge clk_bus);
        // R1: reset state while resets are held
        check("R1 busy", DW'(busy), '0);
        check("R1 osr", osr_val, '0);
        check("R1 ctl", ctl_val, '0);
        #1 rst_n = 1'b1;

        // R7 / R2 / R3: single writes to each register
        write1(1'b0, 8'h5A);
        check("R2 busy after accept", DW'(busy), 8'd1);
        wait_idle();
        check("R7 osr addr0", osr_val, 8'h5A);
        check("R3 ctl untouched", ctl_val, 8'h00);
        write1(1'b1, 8'hC3);
        wait_idle();
        check("R7 ctl addr1", ctl_val, 8'hC3);
        check("R3 osr untouched", osr_val, 8'h5A);

        // R6: write to the other register right after, then R5: same register later
        write1(1'b0, 8'h11);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h22;
        @(negedge clk_bus);
        wr_en = 1'b0;
        repeat (2) @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h33;
        @(negedge clk_bus);
        wr_en = 1'b0;
        wait_idle();
        check("R6 ctl dropped", ctl_val, 8'hC3);
        check("R5 osr kept first", osr_val, 8'h11);

        // R6: same register twice back to back
        write1(1'b1, 8'h66);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h77;
        @(negedge clk_bus);
        wr_en = 1'b0;
        wait_idle();
        check("R6 ctl same-reg drop", ctl_val, 8'h66);

        // R8: inputs change after acceptance
        write1(1'b1, 8'h44);
        wr_addr = 1'b0; wr_data = 8'hEE;
        wait_idle();
        check("R8 ctl held data", ctl_val, 8'h44);
        check("R8 osr untouched", osr_val, 8'h11);

        // R9: strobe held high across transfers
        @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h81;
        @(negedge clk_bus);
        wr_data = 8'h99;
        repeat (30) @(negedge clk_bus);
        wr_en = 1'b0;
        wait_idle();
        check("R9 osr last accepted", osr_val, 8'h99);
        check("R9 ctl untouched", ctl_val, 8'h44);

        repeat (5) @(negedge clk_bus);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule